// File: doc/BRIEF.md
# Serial Trigger-Object Frame Packer

This block sits on a fast clock that runs seven cycles per bunch crossing. Each crossing delivers a burst of seven 32-bit trigger-object words, one per cycle. A start marker is raised with the first word, and every word carries its own valid flag. The block captures the first six words and their flags. The seventh word is thrown away, because a trailer takes its slot further down the chain. At the start marker it also latches a 7-bit crossing tag and a 4-bit error code. It then presents all of this as one 209-bit record and raises a one-cycle ready strobe, so that storage downstream can keep one record per crossing.

A start marker that arrives before a burst is complete abandons the partial burst. It restarts capture from that marker and sets a sticky framing-error flag. Words that arrive outside a burst are ignored.

Top module: `tob_frame_packer`

## Requirements
- R1: While reset is asserted, and after it is released, `rec_o` is all zeros and `rec_rdy_o` and `frame_err_o` are 0, until the first record or error occurs.
- R2: The word presented with `sync_i` high is word 0, and the following words are words 1 to 6. Word i (i = 0..5) appears in record bits [32*i+31 : 32*i], so word 0 is in bits 31:0 and word 5 is in bits 191:160.
- R3: Record bit 192+i holds the `word_vld_i` value that came with word i, for i = 0..5, which gives the 6-bit mask in bits 197:192.
- R4: Record bits 208:202 hold `xing_i` and bits 201:198 hold `err_i`, both sampled in the cycle where `sync_i` is high. Changes on those inputs later in the burst have no effect.
- R5: Word 6 and its valid flag have no effect on the record.
- R6: `rec_rdy_o` is high for exactly one cycle: the cycle after word 6 is sampled, which is seven clocks after the sampled `sync_i`. `rec_o` changes only together with that strobe and holds its value otherwise.
- R7: Words presented while no burst is in progress and `sync_i` is low are ignored. They change neither `rec_o` nor `rec_rdy_o`.
- R8: A `sync_i` sampled while words 1 to 6 of a burst are still expected drops the partial burst without a strobe. It sets `frame_err_o` and starts a new burst with that cycle's word as word 0.
- R9: A `sync_i` in the cycle right after word 6 begins a new burst without a framing error, so records can follow every seven cycles.
- R10: `frame_err_o` stays high once set and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, seven cycles per crossing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_i | input | 1 | Marks word 0 of a burst |
| word_i | input | 32 | Serial trigger-object word |
| word_vld_i | input | 1 | Valid flag of the current word |
| xing_i | input | 7 | Crossing tag, sampled with `sync_i` |
| err_i | input | 4 | Error code, sampled with `sync_i` |
| rec_o | output | 209 | Packed record: tag, error, mask, six words |
| rec_rdy_o | output | 1 | One-cycle strobe when a new record is on `rec_o` |
| frame_err_o | output | 1 | Sticky flag for a burst cut short by an early `sync_i` |

## Verification
The assertions assume that `sync_i` stays low while the internal synchronized reset is still held, which covers the two cycles after `rst_n` rises. They also assume that the inputs settle away from the rising edge. The bench drives every input on the falling edge. After each reset it waits several cycles before it sends the first start marker. It sends idle words only after a complete burst, so any burst cut short is always ended by an early `sync_i`, which is exactly the condition the framing-error property expects.

// File: rtl/tfp_pkg.sv
`timescale 1ns/1ps
package tfp_pkg;
  localparam int unsigned TFP_WORD_W    = 32;
  localparam int unsigned TFP_FRAME_LEN = 7;
  localparam int unsigned TFP_KEEP      = 6;
  localparam int unsigned TFP_XING_W    = 7;
  localparam int unsigned TFP_ERR_W     = 4;

  // record layout: {tag, error, mask, words}
  function automatic int unsigned tfp_rec_w(input int unsigned word_w,
                                            input int unsigned keep,
                                            input int unsigned xing_w,
                                            input int unsigned err_w);
    return xing_w + err_w + keep + keep * word_w;
  endfunction
endpackage

// File: rtl/tfp_rst_sync.sv
`timescale 1ns/1ps
module tfp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/tfp_frame_seq.sv
`timescale 1ns/1ps
module tfp_frame_seq #(
  parameter int unsigned FRAME_LEN = 7,
  parameter int unsigned KEEP      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  output logic [KEEP-1:0] lane_we_o,
  output logic            hdr_we_o,
  output logic            publish_o,
  output logic            frame_err_o
);
  localparam int unsigned        IDX_W    = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0]   NEXT_IDX = IDX_W'(1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;
  logic             last_word;

  assign last_word = active_q && !sync_i && (idx_q == LAST_IDX);

  // next-state logic
  always_comb begin
    active_d  = active_q;
    idx_d     = idx_q;
    err_d     = err_q;
    hdr_we_o  = 1'b0;
    publish_o = 1'b0;
    if (sync_i) begin
      err_d    = err_q | active_q;
      active_d = 1'b1;
      idx_d    = NEXT_IDX;
      hdr_we_o = 1'b1;
    end else if (active_q) begin
      if (last_word) begin
        active_d  = 1'b0;
        idx_d     = '0;
        publish_o = 1'b1;
      end else begin
        idx_d = idx_q + NEXT_IDX;
      end
    end
  end

  // lane write enables, one per kept word
  for (genvar k = 0; k < KEEP; k++) begin : g_we
    if (k == 0) begin : g_first
      assign lane_we_o[k] = sync_i;
    end else begin : g_rest
      assign lane_we_o[k] = active_q && !sync_i && (idx_q == IDX_W'(k));
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      err_q    <= err_d;
    end
  end

  assign frame_err_o = err_q;
endmodule

// File: rtl/tfp_lane_bank.sv
`timescale 1ns/1ps
module tfp_lane_bank #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned KEEP   = 6,
  parameter int unsigned XING_W = 7,
  parameter int unsigned ERR_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [KEEP-1:0]        lane_we_i,
  input  logic                   hdr_we_i,
  input  logic [WORD_W-1:0]      word_i,
  input  logic                   vld_i,
  input  logic [XING_W-1:0]      xing_i,
  input  logic [ERR_W-1:0]       err_i,
  output logic [KEEP*WORD_W-1:0] data_o,
  output logic [KEEP-1:0]        mask_o,
  output logic [XING_W-1:0]      xing_o,
  output logic [ERR_W-1:0]       err_o
);
  for (genvar k = 0; k < KEEP; k++) begin : g_lane
    logic [WORD_W-1:0] data_q;
    logic              vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else if (lane_we_i[k]) begin
        data_q <= word_i;
        vld_q  <= vld_i;
      end
    end

    assign data_o[k*WORD_W +: WORD_W] = data_q;
    assign mask_o[k]                  = vld_q;
  end

  logic [XING_W-1:0] xing_q;
  logic [ERR_W-1:0]  err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xing_q <= '0;
      err_q  <= '0;
    end else if (hdr_we_i) begin
      xing_q <= xing_i;
      err_q  <= err_i;
    end
  end

  assign xing_o = xing_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tob_frame_packer.sv
`timescale 1ns/1ps
module tob_frame_packer #(
  parameter int unsigned WORD_W    = tfp_pkg::TFP_WORD_W,
  parameter int unsigned FRAME_LEN = tfp_pkg::TFP_FRAME_LEN,
  parameter int unsigned KEEP      = tfp_pkg::TFP_KEEP,
  parameter int unsigned XING_W    = tfp_pkg::TFP_XING_W,
  parameter int unsigned ERR_W     = tfp_pkg::TFP_ERR_W,
  parameter int unsigned REC_W     = tfp_pkg::tfp_rec_w(WORD_W, KEEP, XING_W, ERR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic [XING_W-1:0] xing_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              rec_rdy_o,
  output logic              frame_err_o
);
  logic                   rst_core_n;
  logic [KEEP-1:0]        lane_we;
  logic                   hdr_we;
  logic                   publish;
  logic [KEEP*WORD_W-1:0] stage_data;
  logic [KEEP-1:0]        stage_mask;
  logic [XING_W-1:0]      stage_xing;
  logic [ERR_W-1:0]       stage_err;
  logic [REC_W-1:0]       rec_d, rec_q;
  logic                   rdy_q;

  tfp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tfp_frame_seq #(.FRAME_LEN(FRAME_LEN), .KEEP(KEEP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sync_i      (sync_i),
    .lane_we_o   (lane_we),
    .hdr_we_o    (hdr_we),
    .publish_o   (publish),
    .frame_err_o (frame_err_o)
  );

  tfp_lane_bank #(.WORD_W(WORD_W), .KEEP(KEEP), .XING_W(XING_W), .ERR_W(ERR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .lane_we_i (lane_we),
    .hdr_we_i  (hdr_we),
    .word_i    (word_i),
    .vld_i     (word_vld_i),
    .xing_i    (xing_i),
    .err_i     (err_i),
    .data_o    (stage_data),
    .mask_o    (stage_mask),
    .xing_o    (stage_xing),
    .err_o     (stage_err)
  );

  always_comb begin
    rec_d = {stage_xing, stage_err, stage_mask, stage_data};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rec_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= publish;
      if (publish) begin
        rec_q <= rec_d;
      end
    end
  end

  assign rec_o     = rec_q;
  assign rec_rdy_o = rdy_q;
endmodule

// File: rtl/tfp_chk.sv
`timescale 1ns/1ps
module tfp_chk #(
  parameter int unsigned FRAME_LEN = 7,
  parameter int unsigned REC_W     = 209
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             sync_i,
  input logic [REC_W-1:0] rec_o,
  input logic             rec_rdy_o,
  input logic             frame_err_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

  // cycles since the last sampled start marker, saturating at a full burst
  logic [CNT_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      since_q <= '0;
    end else if (sync_i) begin
      since_q <= CNT_W'(1);
    end else if (since_q != '0 && since_q != FULL) begin
      since_q <= since_q + CNT_W'(1);
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_core_n) begin
      reset_clear_chk: assert (rec_o == '0 && !rec_rdy_o && !frame_err_o);
    end
  end

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rec_rdy_o |=> !rec_rdy_o);

  // R6
  strobe_timing_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rec_rdy_o |-> since_q == FULL);

  // R6
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(rec_o) |-> rec_rdy_o);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(frame_err_o) |-> ($past(sync_i) && $past(since_q) != '0 && $past(since_q) != FULL));

  // R9
  clean_sync_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sync_i && (since_q == '0 || since_q == FULL) && !frame_err_o) |=> !frame_err_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_err_o |=> frame_err_o);
endmodule

bind tob_frame_packer tfp_chk #(.FRAME_LEN(FRAME_LEN), .REC_W(REC_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .sync_i      (sync_i),
  .rec_o       (rec_o),
  .rec_rdy_o   (rec_rdy_o),
  .frame_err_o (frame_err_o)
);

// File: tb/sim_tob_frame_packer.sv
`timescale 1ns/1ps
module sim_tob_frame_packer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_i = 1'b0;
  logic [31:0]  word_i = '0;
  logic         word_vld_i = 1'b0;
  logic [6:0]   xing_i = '0;
  logic [3:0]   err_i = '0;
  logic [208:0] rec_o;
  logic         rec_rdy_o;
  logic         frame_err_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int due = -1;
  int ferr_at = -1;
  bit mon_en = 1'b1;
  bit in_burst = 1'b0;
  bit done = 1'b0;
  string phase = "R1";
  logic [208:0] cur_exp = '0;
  logic [208:0] pend = '0;

  logic [31:0] fw [7];
  logic        fv [7];
  logic [6:0]  fx;
  logic [3:0]  fe;

  tob_frame_packer u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .word_i(word_i),
    .word_vld_i(word_vld_i), .xing_i(xing_i), .err_i(err_i),
    .rec_o(rec_o), .rec_rdy_o(rec_rdy_o), .frame_err_o(frame_err_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [208:0] pack_rec();
    logic [208:0] r;
    r = '0;
    for (int i = 0; i < 6; i++) begin
      r[32*i +: 32] = fw[i];
      r[192+i]      = fv[i];
    end
    r[201:198] = fe;
    r[208:202] = fx;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [208:0] act, input logic [208:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor on the falling edge
  always @(negedge clk) begin
    if (mon_en && !done) begin
      if (cyc == due) begin
        cur_exp = pend;
        chk(rec_rdy_o === 1'b1, "R6 strobe", 209'(rec_rdy_o), 209'(1));
      end else begin
        chk(rec_rdy_o === 1'b0, "R6 no-strobe", 209'(rec_rdy_o), 209'(0));
      end
      chk(rec_o === cur_exp, phase, rec_o, cur_exp);
      chk(frame_err_o === (ferr_at >= 0 && cyc >= ferr_at), "R8/R10 frame_err",
          209'(frame_err_o), 209'(ferr_at >= 0 && cyc >= ferr_at));
    end
  end

  task automatic fill_rand();
    for (int i = 0; i < 7; i++) begin
      fw[i] = $urandom;
      fv[i] = 1'($urandom);
    end
    fx = 7'($urandom);
    fe = 4'($urandom);
  endtask

  task automatic send_frame(input int n, input bit scramble, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase      = req;
      sync_i     = (i == 0);
      word_i     = fw[i];
      word_vld_i = fv[i];
      if (i == 0) begin
        if (in_burst && ferr_at < 0) ferr_at = cyc + 1;
        in_burst = 1'b1;
        xing_i   = fx;
        err_i    = fe;
      end else if (scramble) begin
        xing_i = 7'($urandom);
        err_i  = 4'($urandom);
      end
      if (i == 6) begin
        pend     = pack_rec();
        due      = cyc + 1;
        in_burst = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase      = req;
      sync_i     = 1'b0;
      word_i     = $urandom;
      word_vld_i = 1'($urandom);
      xing_i     = 7'($urandom);
      err_i      = 4'($urandom);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n    = 1'b0;
    sync_i   = 1'b0;
    cur_exp  = '0;
    due      = -1;
    ferr_at  = -1;
    in_burst = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;
    phase  = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: distinct words in known order, all valid
    for (int i = 0; i < 7; i++) begin
      fw[i] = 32'hA000_0000 + 32'(i);
      fv[i] = 1'b1;
    end
    fx = 7'h55; fe = 4'hA;
    send_frame(7, 1'b0, "R2 word order");
    idle(3, "R2 word order");

    // R3: sparse valid mask
    fv[0] = 1'b1; fv[1] = 1'b0; fv[2] = 1'b0; fv[3] = 1'b1; fv[4] = 1'b0; fv[5] = 1'b1; fv[6] = 1'b1;
    send_frame(7, 1'b0, "R3 valid mask");
    idle(2, "R3 valid mask");

    // R4: tag and error change mid-burst
    fx = 7'h7F; fe = 4'h1;
    send_frame(7, 1'b1, "R4 header sampling");
    idle(2, "R4 header sampling");

    // R5: only word 6 differs
    fw[6] = 32'hDEAD_BEEF; fv[6] = 1'b0;
    send_frame(7, 1'b0, "R5 word6 dropped");
    idle(2, "R5 word6 dropped");

    // R7: long idle with junk
    idle(20, "R7 idle ignored");

    // R9: back-to-back bursts
    for (int k = 0; k < 3; k++) begin
      fill_rand();
      send_frame(7, 1'b0, "R9 back-to-back");
    end
    idle(2, "R9 back-to-back");

    // R8: burst cut after three words, then after six words
    fill_rand();
    send_frame(3, 1'b0, "R8 early sync");
    fill_rand();
    send_frame(7, 1'b0, "R8 restart");
    fill_rand();
    send_frame(6, 1'b0, "R8 sync at word6");
    fill_rand();
    send_frame(7, 1'b0, "R8 restart");
    idle(3, "R10 sticky");

    // random mix
    for (int k = 0; k < 150; k++) begin
      int op;
      op = int'($urandom % 8);
      fill_rand();
      if (op == 0) begin
        idle(1 + int'($urandom % 5), "R7 random idle");
      end else if (op == 1) begin
        send_frame(1 + int'($urandom % 6), 1'($urandom), "R8 random cut");
        fill_rand();
        send_frame(7, 1'($urandom), "R8 random restart");
      end else begin
        send_frame(7, 1'($urandom), "R9 random burst");
      end
    end
    idle(4, "R10 sticky");

    // R10 / R1: reset clears the sticky flag and the record
    do_reset();
    fill_rand();
    send_frame(7, 1'b0, "R2 after reset");
    idle(4, "R2 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule